// File: doc/BRIEF.md
# Parameter Block Fetch Controller

This block sets up the operating parameters of a DMA-driven network controller. Software writes a 24-bit parameter-block address into two host-visible registers. The low register holds 16 bits and the high register holds 8 bits. Software then issues an init command. The controller reads twelve consecutive 16-bit words from memory over a simple request/grant read port, one word at a time. It loads the mode register and the receive and transmit ring descriptors from the first four words, and reads the remaining eight without keeping them.

When the last word has been written into the internal registers, the block raises a done flag. If interrupts are enabled it also raises its interrupt line. Software acknowledges by writing a one to the done-clear command bit. As an alternative, software can write the mode, ring bases and ring lengths directly. A later init command replaces those values with the fetched ones.

The transmit and receive sections count as running only after a start command and a completed init. Each section can also be disabled through its own mode bit.

Top module: `param_fetch`

## Requirements
- R1: A command write with bit 0 set, accepted while idle, raises `mem_req` on the next cycle with `mem_addr` = {high register, low register}.
- R2: Exactly 12 word reads are issued, at byte addresses base + 2*i (i = 0..11) in order, with 24-bit wrap-free addition. A new request is issued only after the previous word returned on `mem_rvalid`, and the address holds while a request waits for `mem_gnt`.
- R3: `init_done` rises only after the twelfth word was returned, and all loaded registers already hold their new values in the cycle it is first seen.
- R4: `irq` is high exactly while `init_done` is set and the interrupt enable is set. The enable is bit 2 of every command write.
- R5: A command write with bit 3 set clears `init_done` and therefore `irq`.
- R6: Direct writes (`dir_sel` 0 = mode, 1 = receive base, 2 = transmit base, 3 = lengths with receive in [7:4] and transmit in [3:0]) update the registers at once. A later init overwrites all of them with fetched values.
- R7: Ring base addresses always have bits [2:0] zero, whether written directly or fetched.
- R8: Word layout: word 0 = mode. Word 1 = receive base [15:0]. Word 2 = transmit base [15:0]. Word 3 = {receive length [15:12], transmit length [11:8], shared base bits [23:16] in [7:0]}. Words 4 to 11 are read and discarded.
- R9: Mode bit 0 disables receive and mode bit 1 disables transmit. `rx_on`/`tx_on` = started and init completed and not disabled.
- R10: A start command (bit 1) without a completed init leaves both sections off. During a fetch both are off, and they come on once the fetch completes.
- R11: An init command that arrives while a fetch is running is ignored: no extra reads are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 4 | Bit 0 init, bit 1 start, bit 2 interrupt enable, bit 3 done clear |
| adr_lo_wr | input | 1 | Write strobe for the low address register |
| adr_lo_wdata | input | 16 | Low 16 address bits |
| adr_hi_wr | input | 1 | Write strobe for the high address register |
| adr_hi_wdata | input | 8 | High 8 address bits |
| dir_wr | input | 1 | Direct register write strobe |
| dir_sel | input | 2 | Direct write target |
| dir_wdata | input | 24 | Direct write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Byte address of the requested word |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| mode | output | 16 | Mode register |
| rx_base | output | 24 | Receive ring base |
| tx_base | output | 24 | Transmit ring base |
| rx_len | output | 4 | Receive ring length code |
| tx_len | output | 4 | Transmit ring length code |
| init_done | output | 1 | Init complete flag |
| fetch_busy | output | 1 | Fetch in progress |
| irq | output | 1 | Interrupt |
| tx_on | output | 1 | Transmit section running |
| rx_on | output | 1 | Receive section running |

## Verification
On every cycle, the embedded properties check four things. A pending request holds its address until granted. The done flag never rises while a read is outstanding. A done-clear write drops the flag and the interrupt. Both sections stay off while a fetch runs. Only the directed scenarios can show the rest: the exact address sequence and read count, the word-to-register mapping with forced alignment, the overwrite of directly written values, the mode-bit gating, and that an init arriving mid-fetch is ignored.

// File: rtl/param_fetch.sv
module param_fetch #(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int NWORDS = 12,
  parameter int LENW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [3:0]    cmd_wdata,
  input  logic          adr_lo_wr,
  input  logic [DW-1:0] adr_lo_wdata,
  input  logic          adr_hi_wr,
  input  logic [AW-DW-1:0] adr_hi_wdata,
  input  logic          dir_wr,
  input  logic [1:0]    dir_sel,
  input  logic [AW-1:0] dir_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mode,
  output logic [AW-1:0] rx_base,
  output logic [AW-1:0] tx_base,
  output logic [LENW-1:0] rx_len,
  output logic [LENW-1:0] tx_len,
  output logic          init_done,
  output logic          fetch_busy,
  output logic          irq,
  output logic          tx_on,
  output logic          rx_on
);
  localparam int HW = AW - DW;
  localparam int IW = $clog2(NWORDS);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} state_t;
  state_t state;

  logic [DW-1:0] adr_lo;
  logic [HW-1:0] adr_hi;
  logic [AW-1:0] fbase;
  logic [IW-1:0] idx;
  logic ien, started, init_ok;

  wire do_init = cmd_wr && cmd_wdata[0] && state == S_IDLE;

  assign mem_req    = state == S_REQ;
  assign mem_addr   = fbase + AW'({idx, 1'b0});
  assign fetch_busy = state != S_IDLE;
  assign irq        = init_done && ien;
  assign rx_on      = started && init_ok && !mode[0];
  assign tx_on      = started && init_ok && !mode[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      adr_lo <= '0;
      adr_hi <= '0;
      fbase <= '0;
      idx <= '0;
      ien <= 1'b0;
      started <= 1'b0;
      init_ok <= 1'b0;
      init_done <= 1'b0;
      mode <= '0;
      rx_base <= '0;
      tx_base <= '0;
      rx_len <= '0;
      tx_len <= '0;
    end else begin
      if (cmd_wr) begin
        ien <= cmd_wdata[2];
        if (cmd_wdata[1]) started <= 1'b1;
        if (cmd_wdata[3]) init_done <= 1'b0;
      end
      if (adr_lo_wr) adr_lo <= adr_lo_wdata;
      if (adr_hi_wr) adr_hi <= adr_hi_wdata;
      if (dir_wr) begin
        unique case (dir_sel)
          2'd0: mode <= dir_wdata[DW-1:0];
          2'd1: rx_base <= {dir_wdata[AW-1:3], 3'b000};
          2'd2: tx_base <= {dir_wdata[AW-1:3], 3'b000};
          default: begin
            rx_len <= dir_wdata[2*LENW-1:LENW];
            tx_len <= dir_wdata[LENW-1:0];
          end
        endcase
      end
      unique case (state)
        S_IDLE: if (do_init) begin
          state <= S_REQ;
          idx <= '0;
          fbase <= {adr_hi, adr_lo};
          init_ok <= 1'b0;
          init_done <= 1'b0;
        end
        S_REQ: if (mem_gnt) state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (idx == IW'(0)) mode <= mem_rdata;
          if (idx == IW'(1)) rx_base[DW-1:0] <= {mem_rdata[DW-1:3], 3'b000};
          if (idx == IW'(2)) tx_base[DW-1:0] <= {mem_rdata[DW-1:3], 3'b000};
          if (idx == IW'(3)) begin
            rx_base[AW-1:DW] <= mem_rdata[HW-1:0];
            tx_base[AW-1:DW] <= mem_rdata[HW-1:0];
            tx_len <= mem_rdata[HW+LENW-1:HW];
            rx_len <= mem_rdata[HW+2*LENW-1:HW+LENW];
          end
          if (idx == IW'(NWORDS-1)) state <= S_FIN;
          else begin
            idx <= idx + 1'b1;
            state <= S_REQ;
          end
        end
        default: begin
          init_done <= 1'b1;
          init_ok <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  p_done_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> !mem_req && !$past(mem_req) && !fetch_busy);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_wdata[3] && !fetch_busy |=> !init_done && !irq);

  p_off_in_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy |-> !tx_on && !rx_on);
endmodule

// File: tb/test_param_fetch.sv
module test_param_fetch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, adr_lo_wr = 0, adr_hi_wr = 0, dir_wr = 0;
  logic [3:0] cmd_wdata = 0;
  logic [15:0] adr_lo_wdata = 0;
  logic [7:0] adr_hi_wdata = 0;
  logic [1:0] dir_sel = 0;
  logic [23:0] dir_wdata = 0;
  logic mem_req, mem_gnt, mem_rvalid;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mode;
  logic [23:0] rx_base, tx_base;
  logic [3:0] rx_len, tx_len;
  logic init_done, fetch_busy, irq, tx_on, rx_on;

  int tests = 0, fails = 0;
  logic [15:0] words [12];
  logic [23:0] exp_base;
  int rd_n = 0, addr_err = 0, proto_err = 0;

  always #5 clk = ~clk;

  param_fetch i_param_fetch (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    int ph = 0;
    logic [23:0] a;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      case (ph)
        0: if (mem_req && rst_n) begin
             mem_gnt = 1; a = mem_addr; ph = 1;
             if (a != exp_base + 24'(2 * rd_n)) addr_err++;
           end
        1: begin mem_gnt = 0; ph = 2; end
        2: begin
             if (mem_req) proto_err++;
             mem_rvalid = 1; mem_rdata = words[rd_n % 12]; rd_n++; ph = 3;
           end
        default: begin mem_rvalid = 0; ph = 0; end
      endcase
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cmd(logic [3:0] v);
    cmd_wr = 1; cmd_wdata = v;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic set_addr(logic [23:0] b);
    adr_lo_wr = 1; adr_hi_wr = 1; adr_lo_wdata = b[15:0]; adr_hi_wdata = b[23:16];
    @(negedge clk);
    adr_lo_wr = 0; adr_hi_wr = 0;
  endtask

  task automatic dwrite(logic [1:0] s, logic [23:0] d);
    dir_wr = 1; dir_sel = s; dir_wdata = d;
    @(negedge clk);
    dir_wr = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && !init_done; i++) @(negedge clk);
  endtask

  task automatic check_loaded(string tag);
    check({tag, " R8 mode"}, 32'(mode), 32'(words[0]));
    check({tag, " R7 R8 rx_base"}, 32'(rx_base), 32'({words[3][7:0], words[1][15:3], 3'b000}));
    check({tag, " R7 R8 tx_base"}, 32'(tx_base), 32'({words[3][7:0], words[2][15:3], 3'b000}));
    check({tag, " R8 rx_len"}, 32'(rx_len), 32'(words[3][15:12]));
    check({tag, " R8 tx_len"}, 32'(tx_len), 32'(words[3][11:8]));
  endtask

  task automatic fetch(logic [23:0] b, logic [3:0] c, string tag);
    set_addr(b);
    exp_base = b; rd_n = 0; addr_err = 0; proto_err = 0;
    cmd(c);
    check({tag, " R1 mem_req"}, 32'(mem_req), 1);
    check({tag, " R1 mem_addr"}, 32'(mem_addr), 32'(b));
    wait_done();
    check({tag, " R3 done"}, 32'(init_done), 1);
    check({tag, " R2 R3 reads at done"}, rd_n, 12);
    check({tag, " R2 address order"}, addr_err, 0);
    check({tag, " R2 one outstanding"}, proto_err, 0);
    check_loaded(tag);
  endtask

  task automatic t_reset();
    check("R1 reset mem_req", 32'(mem_req), 0);
    check("R3 reset done", 32'(init_done), 0);
    check("R4 reset irq", 32'(irq), 0);
    check("R10 reset on", 32'({tx_on, rx_on}), 0);
  endtask

  task automatic t_basic();
    words[0] = 16'h0000; words[1] = 16'hBEEF; words[2] = 16'h5557; words[3] = 16'h73C2;
    for (int i = 4; i < 12; i++) words[i] = 16'(i * 16'h1111);
    fetch(24'h4A1230, 4'h1, "basic");
    check("R4 no irq when disabled", 32'(irq), 0);
  endtask

  task automatic t_irq();
    cmd(4'h4);
    check("R4 irq with done and enable", 32'(irq), 1);
    cmd(4'hC);
    check("R5 done cleared", 32'(init_done), 0);
    check("R5 irq cleared", 32'(irq), 0);
    words[3] = 16'h2A10;
    set_addr(24'h000200);
    exp_base = 24'h000200; rd_n = 0;
    cmd(4'h5);
    repeat (4) @(negedge clk);
    check("R4 irq low during fetch", 32'(irq), 0);
    wait_done();
    check("R4 irq after done", 32'(irq), 1);
    cmd(4'h8);
    check("R4 irq low with enable off", 32'(irq), 0);
  endtask

  task automatic t_direct();
    dwrite(2'd0, 24'h000003);
    dwrite(2'd1, 24'h123457);
    dwrite(2'd2, 24'hABCDEF);
    dwrite(2'd3, 24'h0000A5);
    check("R6 direct mode", 32'(mode), 3);
    check("R6 R7 direct rx_base", 32'(rx_base), 32'h123450);
    check("R6 R7 direct tx_base", 32'(tx_base), 32'hABCDE8);
    check("R6 direct rx_len", 32'(rx_len), 4'hA);
    check("R6 direct tx_len", 32'(tx_len), 4'h5);
    words[0] = 16'h0000; words[1] = 16'h0F0F; words[2] = 16'hF0F1; words[3] = 16'h1E99;
    fetch(24'h00FFF8, 4'h1, "R6 overwrite");
  endtask

  task automatic t_modes();
    cmd(4'h2);
    check("R9 both on mode 0", 32'({tx_on, rx_on}), 2'b11);
    dwrite(2'd0, 24'h1);
    check("R9 rx disabled", 32'({tx_on, rx_on}), 2'b10);
    dwrite(2'd0, 24'h2);
    check("R9 tx disabled", 32'({tx_on, rx_on}), 2'b01);
    dwrite(2'd0, 24'h3);
    check("R9 both disabled", 32'({tx_on, rx_on}), 2'b00);
  endtask

  task automatic t_start_no_init();
    do_reset();
    cmd(4'h2);
    repeat (3) @(negedge clk);
    check("R10 start without init", 32'({tx_on, rx_on}), 2'b00);
    words[0] = 16'h0000;
    fetch(24'h000040, 4'h1, "R10 init after start");
    check("R10 on after init", 32'({tx_on, rx_on}), 2'b11);
  endtask

  task automatic t_busy_ignore();
    set_addr(24'h001000);
    exp_base = 24'h001000; rd_n = 0; addr_err = 0;
    cmd(4'h1);
    for (int i = 0; i < 100 && rd_n < 3; i++) @(negedge clk);
    set_addr(24'h002000);
    cmd(4'h1);
    wait_done();
    repeat (30) @(negedge clk);
    check("R11 reads count", rd_n, 12);
    check("R11 address unaffected", addr_err, 0);
    check("R11 idle after", 32'(fetch_busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) words[i] = 16'h0;
    exp_base = 0;
    do_reset();
    t_reset();
    t_basic();
    t_irq();
    t_direct();
    t_modes();
    t_start_no_init();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule